// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block produces a pair of complementary, centre-aligned PWM outputs (a normal phase and a counter phase) plus an undelayed reference waveform. The carrier is a triangle built from two up/down counters that run in lockstep, one of them ahead of the other by a fixed dead-time value `p`. The normal-phase output compares the trailing counter against the duty value `n`. The counter-phase output compares the leading counter against `n`. Because the two counters differ by `p`, a gap of `p` count ticks opens on each side of every switching event, and in that gap neither output is active.

Software sets the period `m`, the dead time `p`, the output polarity and a transfer mode. It writes the duty value into a buffer register. Depending on the mode, the buffer is copied into the active duty register at once, at the carrier crest, or at the carrier underflow. Three sticky flags report the crest, a duty match and the underflow. Software clears each flag by writing 0 to its bit. The period, dead time and polarity are captured only while the generator is stopped.

Top module: `cpwm_dt_top`

## Requirements
- R1: While `start_a` or `start_b` is low, `cnt1_o` is held at 0 and `cnt0_o` at `dead_i`. Both PWM pins sit at their idle level and `pwm_ref_o` is 0. With both starts high, the counters advance.
- R2: When running, each cycle with `cnt_en` high steps `cnt1_o` by one. It counts up to `m+1-p` and then down through 0 to FFFFh, where it turns back up. `cnt0_o` always equals `cnt1_o + p` (mod 2^W). One carrier period is `2(m+2-p)` enabled ticks, and the counters hold when `cnt_en` is low. The configuration must satisfy `p <= m <= 2^W-3`.
- R3: Over one carrier period the normal phase is active for `2*max(0, m+1-p-n)` ticks.
- R4: Over one carrier period the counter phase is active for `2*clamp(n+1-p, 0, m+2-p)` ticks. It is therefore never active when `n+1 <= p`.
- R5: The two phases are never active in the same tick. When both active widths are non-zero, the ticks where neither is active add up to `2p` per period.
- R6: When `pol_i` is 0, the pins idle high and are active low. When `pol_i` is 1, they idle low and are active high. `pwm_ref_o` is high (regardless of polarity) for `2*clamp(m+1-n, 0, m+2-p)` ticks per period, and it is high exactly when the counter phase is not active.
- R7: `xfer_mode[1]=0` makes the active duty follow the buffer on the next cycle. `xfer_mode=10b` copies the buffer on the tick where `cnt1_o` reaches `m+1-p`. `xfer_mode=11b` copies it on the tick where `cnt1_o` becomes FFFFh.
- R8: The flags are set by hardware. `flag_o[0]` is set when `cnt0_o` reaches `m+1`. `flag_o[1]` is set when an enabled tick brings `cnt0_o` to the active duty. `flag_o[2]` is set when `cnt1_o` underflows and reloads with FFFFh.
- R9: Each flag stays set until a cycle with `flag_wr` high and a 0 in its bit of `flag_wdata`. A 1 in a bit leaves that flag unchanged, and a hardware set wins over a clear in the same cycle.
- R10: After reset, the flags are 0, `cnt1_o` is 0, and the outputs are at the idle level for polarity 0 (PWM pins high, `pwm_ref_o` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-source enable, one tick per high cycle |
| start_a | input | 1 | Start bit of counter 0 |
| start_b | input | 1 | Start bit of counter 1 |
| period_i | input | W | Period value m |
| dead_i | input | W | Dead-time value p |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | W | Duty value n for the buffer |
| xfer_mode | input | 2 | Buffer transfer point select |
| pol_i | input | 1 | Output polarity select |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 3 | Flag write data, 0 clears a bit |
| pwm_norm_o | output | 1 | Normal-phase output |
| pwm_comp_o | output | 1 | Counter-phase output |
| pwm_ref_o | output | 1 | Reference waveform without dead time |
| flag_o | output | 3 | Crest, duty-match and underflow flags |
| cnt0_o | output | W | Leading counter value |
| cnt1_o | output | W | Trailing counter value |

## Verification
The assertions check these properties on every cycle:
- the two phases never overlap;
- the counter offset stays equal to `p`;
- the trailing counter stays within its triangle range;
- the counters hold without `cnt_en`;
- the underflow reloads FFFFh and raises its flag;
- a stopped generator drives no active phase;
- the counter phase stays silent when `n < p`;
- flags persist until a clearing write.

Only the bench scenarios can show the following:
- the per-period widths of the two phases, of the dead time and of the reference, against the arithmetic formulas over a sweep of `m`, `p`, `n` and polarity;
- the exact carrier point at which each transfer mode applies a new duty;
- the flag-write semantics.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_CREST = 0;
  localparam int FLG_MATCH = 1;
  localparam int FLG_UFLOW = 2;
endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_q,
  input  logic               run,
  input  logic               tick,
  input  logic [W-1:0]       m_q,
  input  logic [W-1:0]       p_q,
  input  logic [W-1:0]       p_load,
  output logic [W-1:0]       cnt0_q,
  output logic [W-1:0]       cnt1_q,
  output cpwm_pkg::dir_e     dir_q,
  output logic [W-1:0]       cnt0_nx,
  output logic               step,
  output logic               crest,
  output logic               uflow
);
  import cpwm_pkg::*;

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W-1:0] cnt1_nx;
  dir_e         dir_nx;
  logic [W-1:0] top1;

  // crest value of the trailing counter
  assign top1 = m_q + ONE - p_q;
  assign step = run & tick;

  always_comb begin
    cnt0_nx = cnt0_q;
    cnt1_nx = cnt1_q;
    dir_nx  = dir_q;
    crest   = 1'b0;
    uflow   = 1'b0;
    if (!run) begin
      cnt1_nx = '0;
      cnt0_nx = p_load;
      dir_nx  = DIR_UP;
    end else if (tick) begin
      if (dir_q == DIR_UP) begin
        cnt1_nx = cnt1_q + ONE;
        cnt0_nx = cnt0_q + ONE;
        if (cnt1_nx == top1) begin
          dir_nx = DIR_DN;
          crest  = 1'b1;
        end
      end else begin
        cnt1_nx = cnt1_q - ONE;
        cnt0_nx = cnt0_q - ONE;
        if (cnt1_nx == ALL1) begin
          dir_nx = DIR_UP;
          uflow  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt0_q <= '0;
      cnt1_q <= '0;
      dir_q  <= DIR_UP;
    end else begin
      cnt0_q <= cnt0_nx;
      cnt1_q <= cnt1_nx;
      dir_q  <= dir_nx;
    end
  end
endmodule

// File: rtl/cpwm_duty.sv
module cpwm_duty #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   mode,
  input  logic         crest,
  input  logic         uflow,
  output logic [W-1:0] duty_act
);
  logic [W-1:0] buf_q, buf_nx, act_nx;
  logic         xfer;

  always_comb begin
    buf_nx = wr ? wdata : buf_q;
    // mode[1]=0: follow buffer; 10: crest; 11: underflow
    if (!run || !mode[1]) xfer = 1'b1;
    else if (!mode[0])    xfer = crest;
    else                  xfer = uflow;
    act_nx = xfer ? buf_q : duty_act;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      buf_q    <= '0;
      duty_act <= '0;
    end else begin
      buf_q    <= buf_nx;
      duty_act <= act_nx;
    end
  end
endmodule

// File: rtl/cpwm_flags.sv
module cpwm_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [N-1:0] set_i,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] flags_nx;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // hardware set wins over a software clear
    assign flags_nx[i] = set_i[i] | (flags_q[i] & ~(wr & ~wdata[i]));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) flags_q <= '0;
    else        flags_q <= flags_nx;
  end
endmodule

// File: rtl/cpwm_outgen.sv
module cpwm_outgen #(
  parameter int W = 16
) (
  input  logic           run,
  input  cpwm_pkg::dir_e dir,
  input  logic [W-1:0]   cnt0,
  input  logic [W-1:0]   cnt1,
  input  logic [W-1:0]   duty,
  input  logic           pol,
  output logic           norm_act,
  output logic           comp_act,
  output logic           norm_pin,
  output logic           comp_pin,
  output logic           ref_pin
);
  import cpwm_pkg::*;

  logic         up;
  logic [W-1:0] k0, k1;

  // rising states count one higher so each key value occurs twice per period
  assign up = (dir == DIR_UP);
  assign k0 = cnt0 + {{(W-1){1'b0}}, up};
  assign k1 = cnt1 + {{(W-1){1'b0}}, up};

  always_comb begin
    comp_act = run && (k0 <= duty);
    norm_act = run && (k1 > duty);
    ref_pin  = run && !(k0 <= duty);
    norm_pin = pol ? norm_act : ~norm_act;
    comp_pin = pol ? comp_act : ~comp_act;
  end
endmodule

// File: rtl/cpwm_dt_top.sv
module cpwm_dt_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         start_a,
  input  logic         start_b,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] dead_i,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  input  logic [1:0]   xfer_mode,
  input  logic         pol_i,
  input  logic         flag_wr,
  input  logic [2:0]   flag_wdata,
  output logic         pwm_norm_o,
  output logic         pwm_comp_o,
  output logic         pwm_ref_o,
  output logic [2:0]   flag_o,
  output logic [W-1:0] cnt0_o,
  output logic [W-1:0] cnt1_o
);
  import cpwm_pkg::*;

  logic [1:0]   rs_q;
  logic         rst_q;
  logic         run;
  logic [W-1:0] m_q, p_q, m_nx, p_nx;
  logic         pol_q, pol_nx;
  logic [W-1:0] cnt0_q, cnt1_q, cnt0_nx;
  dir_e         dir_q;
  logic         step, crest, uflow;
  logic [W-1:0] duty_act;
  logic         norm_act, comp_act;
  logic [NUM_FLAGS-1:0] flag_set, flags_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  assign run = start_a & start_b;

  // configuration is captured only while stopped
  always_comb begin
    m_nx   = run ? m_q   : period_i;
    p_nx   = run ? p_q   : dead_i;
    pol_nx = run ? pol_q : pol_i;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      m_q   <= '0;
      p_q   <= '0;
      pol_q <= 1'b0;
    end else begin
      m_q   <= m_nx;
      p_q   <= p_nx;
      pol_q <= pol_nx;
    end
  end

  cpwm_carrier #(.W(W)) u_carrier (
    .clk(clk), .rst_q(rst_q), .run(run), .tick(cnt_en),
    .m_q(m_q), .p_q(p_q), .p_load(dead_i),
    .cnt0_q(cnt0_q), .cnt1_q(cnt1_q), .dir_q(dir_q),
    .cnt0_nx(cnt0_nx), .step(step), .crest(crest), .uflow(uflow)
  );

  cpwm_duty #(.W(W)) u_duty (
    .clk(clk), .rst_q(rst_q), .run(run), .wr(duty_wr), .wdata(duty_wdata),
    .mode(xfer_mode), .crest(crest), .uflow(uflow), .duty_act(duty_act)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_CREST] = crest;
    flag_set[FLG_MATCH] = step && (cnt0_nx == duty_act);
    flag_set[FLG_UFLOW] = uflow;
  end

  cpwm_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_q(rst_q), .set_i(flag_set), .wr(flag_wr),
    .wdata(flag_wdata), .flags_q(flags_q)
  );

  cpwm_outgen #(.W(W)) u_out (
    .run(run), .dir(dir_q), .cnt0(cnt0_q), .cnt1(cnt1_q), .duty(duty_act),
    .pol(pol_q), .norm_act(norm_act), .comp_act(comp_act),
    .norm_pin(pwm_norm_o), .comp_pin(pwm_comp_o), .ref_pin(pwm_ref_o)
  );

  assign flag_o = flags_q;
  assign cnt0_o = cnt0_q;
  assign cnt1_o = cnt1_q;
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_q,
  input logic         run,
  input logic         tick,
  input logic         dir_q,
  input logic [W-1:0] cnt0_q,
  input logic [W-1:0] cnt1_q,
  input logic [W-1:0] m_q,
  input logic [W-1:0] p_q,
  input logic [W-1:0] duty_act,
  input logic         norm_act,
  input logic         comp_act,
  input logic [2:0]   flags_q,
  input logic         flag_wr,
  input logic [2:0]   flag_wdata
);
  a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_q)
    !run |-> (!norm_act && !comp_act));

  a_r2_fixed_offset: assert property (@(posedge clk) disable iff (!rst_q)
    run |-> (cnt0_q == cnt1_q + p_q));

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_q)
    run |-> ((cnt1_q == {W{1'b1}}) || (cnt1_q <= m_q + W'(1) - p_q)));

  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_q)
    (run && !tick) |=> (cnt1_q == $past(cnt1_q)));

  a_r4_no_comp_small_duty: assert property (@(posedge clk) disable iff (!rst_q)
    (run && (duty_act < p_q)) |-> !comp_act);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_q)
    !(norm_act && comp_act));

  a_r8_uflow_reload: assert property (@(posedge clk) disable iff (!rst_q)
    (run && tick && dir_q && (cnt1_q == '0)) |=> ((cnt1_q == {W{1'b1}}) && flags_q[2]));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (flags_q[0] && !(flag_wr && !flag_wdata[0])) |=> flags_q[0]);
endmodule

bind cpwm_dt_top cpwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_q(rst_q), .run(run), .tick(cnt_en), .dir_q(dir_q),
  .cnt0_q(cnt0_q), .cnt1_q(cnt1_q), .m_q(m_q), .p_q(p_q),
  .duty_act(duty_act), .norm_act(norm_act), .comp_act(comp_act),
  .flags_q(flags_q), .flag_wr(flag_wr), .flag_wdata(flag_wdata)
);

// File: tb/sim_cpwm_dt_top.sv
`timescale 1ns/1ps
module sim_cpwm_dt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en, start_a, start_b, duty_wr, pol_i, flag_wr;
  logic [15:0] period_i, dead_i, duty_wdata;
  logic [1:0]  xfer_mode;
  logic [2:0]  flag_wdata;
  logic        pwm_norm_o, pwm_comp_o, pwm_ref_o;
  logic [2:0]  flag_o;
  logic [15:0] cnt0_o, cnt1_o;

  int nchk = 0, nfail = 0;
  int cur_pol;
  int s_norm, s_comp, s_ref, s_both, s_idle, s_uf, s_max1, s_offbad;

  always #4 clk = ~clk;

  cpwm_dt_top #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_a(start_a), .start_b(start_b),
    .period_i(period_i), .dead_i(dead_i), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .xfer_mode(xfer_mode), .pol_i(pol_i), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .pwm_norm_o(pwm_norm_o), .pwm_comp_o(pwm_comp_o), .pwm_ref_o(pwm_ref_o),
    .flag_o(flag_o), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk_eq(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  task automatic cfg(int m, int p, int n, int pol, int mode);
    start_a = 0; start_b = 0;
    period_i = 16'(m); dead_i = 16'(p); pol_i = pol[0]; xfer_mode = 2'(mode);
    duty_wr = 1; duty_wdata = 16'(n);
    flag_wr = 1; flag_wdata = 3'b000;
    @(negedge clk);
    duty_wr = 0; flag_wr = 0;
    repeat (3) @(negedge clk);
    cur_pol = pol;
    start_a = 1; start_b = 1;
  endtask

  task automatic wait_uf();
    do @(negedge clk); while (cnt1_o != 16'hFFFF);
  endtask

  // samples len consecutive ticks starting at the current negedge
  task automatic measure(int len, int p);
    logic na, ca;
    logic [15:0] d;
    s_norm = 0; s_comp = 0; s_ref = 0; s_both = 0; s_idle = 0;
    s_uf = 0; s_max1 = 0; s_offbad = 0;
    for (int i = 0; i < len; i++) begin
      if (i == 1) duty_wr = 0;
      na = cur_pol[0] ? pwm_norm_o : !pwm_norm_o;
      ca = cur_pol[0] ? pwm_comp_o : !pwm_comp_o;
      s_norm += int'(na);
      s_comp += int'(ca);
      s_ref  += int'(pwm_ref_o);
      s_both += int'(na & ca);
      s_idle += int'(!na & !ca);
      if (cnt1_o == 16'hFFFF) s_uf++;
      else if (int'(cnt1_o) > s_max1) s_max1 = int'(cnt1_o);
      d = cnt0_o - cnt1_o;
      if (d != 16'(p)) s_offbad++;
      @(negedge clk);
    end
  endtask

  task automatic sweep_one(int m, int p, int n, int pol);
    int per, t, en, ec, er;
    cfg(m, p, n, pol, 0);
    wait_uf();
    per = 2 * (m + 2 - p);
    t = m + 1 - p;
    measure(per, p);
    en = 2 * ((t - n > 0) ? (t - n) : 0);
    ec = 2 * clampi(n + 1 - p, 0, m + 2 - p);
    er = 2 * clampi(m + 1 - n, 0, m + 2 - p);
    chk_eq("R3 normal width", s_norm, en);
    chk_eq("R4 counter width", s_comp, ec);
    chk_eq("R6 reference width", s_ref, er);
    chk_eq("R5 overlap", s_both, 0);
    if (en > 0 && ec > 0) chk_eq("R5 dead time", s_idle, 2 * p);
    chk_eq("R2 one underflow per period", s_uf, 1);
    chk_eq("R2 crest value", s_max1, t);
    chk_eq("R2 counter offset", s_offbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    report();
    $finish;
  end

  initial begin
    int c;
    rst_n = 0; cnt_en = 1; start_a = 0; start_b = 0;
    period_i = 16'd8; dead_i = 16'd3; duty_wr = 0; duty_wdata = 0;
    xfer_mode = 0; pol_i = 0; flag_wr = 0; flag_wdata = 0; cur_pol = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk_eq("R10 flags", int'(flag_o), 0);
    chk_eq("R10 cnt1", int'(cnt1_o), 0);
    chk_eq("R10 norm pin", int'(pwm_norm_o), 1);
    chk_eq("R10 comp pin", int'(pwm_comp_o), 1);
    chk_eq("R10 ref pin", int'(pwm_ref_o), 0);
    chk_eq("R1 cnt0 loaded", int'(cnt0_o), 3);

    // sweep: R2 R3 R4 R5 R6
    for (int m = 5; m <= 8; m += 3)
      for (int p = 0; p <= 3; p++)
        for (int n = 0; n <= m + 2; n++)
          sweep_one(m, p, n, (n + p) % 2);

    // R7 mode 10: old duty on rising half, new duty from crest
    cfg(8, 2, 4, 0, 2);
    wait_uf();
    duty_wr = 1; duty_wdata = 16'd7;
    measure(16, 2);
    chk_eq("R7 crest transfer", s_comp, 9);

    // R7 mode 11: new duty only from next underflow
    cfg(8, 2, 4, 0, 3);
    wait_uf();
    duty_wr = 1; duty_wdata = 16'd7;
    measure(16, 2);
    chk_eq("R7 underflow transfer old period", s_comp, 6);
    measure(16, 2);
    chk_eq("R7 underflow transfer new period", s_comp, 12);

    // R7 mode 00: immediate follow
    cfg(8, 2, 4, 0, 0);
    wait_uf();
    duty_wr = 1; duty_wdata = 16'd7;
    measure(16, 2);
    chk_eq("R7 immediate transfer", s_comp, 12);

    // R8 flags all set, R9 clears
    cfg(8, 2, 4, 0, 0);
    wait_uf();
    wait_uf();
    start_a = 0;
    @(negedge clk);
    chk_eq("R8 all flags set", int'(flag_o), 7);
    flag_wr = 1; flag_wdata = 3'b110;
    @(negedge clk);
    chk_eq("R9 clear crest flag only", int'(flag_o), 6);
    flag_wdata = 3'b011;
    @(negedge clk);
    chk_eq("R9 clear underflow flag only", int'(flag_o), 2);
    flag_wdata = 3'b000;
    @(negedge clk);
    flag_wr = 0;
    chk_eq("R9 clear all", int'(flag_o), 0);

    // R8 boundary: n below p-1 never matches
    cfg(8, 3, 0, 0, 0);
    wait_uf();
    wait_uf();
    start_b = 0;
    @(negedge clk);
    chk_eq("R8 no duty match", int'(flag_o[1]), 0);
    chk_eq("R8 underflow flag", int'(flag_o[2]), 1);
    // R1 stopped state
    chk_eq("R1 stop cnt1", int'(cnt1_o), 0);
    chk_eq("R1 stop cnt0", int'(cnt0_o), 3);
    chk_eq("R1 stop norm idle", int'(pwm_norm_o), 1);
    chk_eq("R1 stop comp idle", int'(pwm_comp_o), 1);
    chk_eq("R1 stop ref", int'(pwm_ref_o), 0);

    // R6 polarity 1 idle low
    cfg(8, 2, 4, 1, 0);
    start_a = 0;
    repeat (2) @(negedge clk);
    chk_eq("R6 pol1 norm idle", int'(pwm_norm_o), 0);
    chk_eq("R6 pol1 comp idle", int'(pwm_comp_o), 0);

    // R2 hold without count enable
    start_a = 1;
    repeat (5) @(negedge clk);
    c = int'(cnt1_o);
    cnt_en = 0;
    repeat (6) @(negedge clk);
    chk_eq("R2 hold without cnt_en", int'(cnt1_o), c);
    cnt_en = 1;
    @(negedge clk);
    nchk++;
    if (int'(cnt1_o) == c) begin
      nfail++;
      $display("FAIL R2 resume act=%0d exp=not %0d", int'(cnt1_o), c);
    end

    report();
    $finish;
  end
endmodule